// File: doc/BRIEF.md
# Bidirectional Timer Counter Unit

This block is the counting core of a timer peripheral. It holds an 8-bit count that moves by one step on each qualified timer tick. A 3-bit clock-select field picks the tick source. The source can be stopped, the system clock itself, one of several prescaled tick taps, or an external tick input. The prescaler divider and any external synchronizer sit outside the block, and every tick arrives as a single-cycle enable that is synchronous to the system clock.

A 2-bit waveform-mode field sets the counting sequence. The sequence can be a single-slope wrap at the full-scale value, a dual-slope up/down sweep, or a clear-on-compare run that resets at a programmable compare value. The block flags the bottom (zero) and the current top of the sequence. It also keeps a sticky overflow flag whose set rule depends on the mode.

A CPU-side write port can load the count in any cycle, whether or not the timer is running. A write takes precedence over whatever the sequence would have done in that cycle.

Top module: `tmr_count_unit`

## Requirements
- R1: In wave_mode 0 (single-slope wrap), each tick increments the count by exactly 1, and 255 wraps to 0. In the up phase of wave_mode 1, each tick also moves the count by exactly 1.
- R2: In wave_mode 2 (clear-on-compare), a tick while the count equals cmp_val loads 0. Otherwise the tick increments the count.
- R3: With clk_sel = 0 and no write, the count holds its value whatever the tick inputs do.
- R4: The clk_sel encoding is as follows. Code 1 ticks on every clock. Codes 2..5 take presc_tick[0..3] respectively. Codes 6 and 7 take ext_tick. A tap that is not selected has no effect on the count.
- R5: When wr_en is high, the count takes wr_data on the next clock edge. This holds whether the timer is stopped or ticking, and it overrides any increment, decrement or clear. A write never sets the overflow flag.
- R6: at_bottom is high exactly when the count is 0. at_top is high exactly when the count equals the top value. The top value is cmp_val in wave_mode 2 and 255 in every other mode.
- R7: In wave_mode 0, 2 and 3, ovf_flag is set by the tick that takes the count from 255 to 0.
- R8: ovf_flag stays set until a cycle with flag_clr high clears it. If a set event and flag_clr occur in the same cycle, the flag ends up set.
- R9: In wave_mode 1 (dual slope), the count rises to 255 and then falls to 0, turning at each end without repeating the end value (254, 255, 254 and 1, 0, 1). The tick that brings the count down to 0 sets ovf_flag. A write keeps the current direction.
- R10: A synchronous active-high reset clears the count, the direction (to up) and ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Tick source select (0 stop, 1 every clock, 2..5 prescaled taps, 6..7 external) |
| presc_tick | input | 4 | Single-cycle prescaled tick taps |
| ext_tick | input | 1 | Single-cycle external tick, already synchronized |
| wave_mode | input | 2 | Counting sequence: 0 wrap, 1 dual slope, 2 clear on compare, 3 wrap |
| cmp_val | input | 8 | Top value for clear-on-compare mode |
| wr_en | input | 1 | CPU write strobe for the count |
| wr_data | input | 8 | CPU write value |
| flag_clr | input | 1 | CPU clear of the overflow flag (write-one-to-clear) |
| count_o | output | 8 | Current count |
| at_top | output | 1 | Count equals the current top value |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench tests the turn points of the dual-slope sweep. A design that repeats an end value, or that loses the direction across a write, yields a wrong count sequence. It tests a write landing in the same cycle as a compare clear, where a design with the wrong priority shows 0 instead of the written value. It tests a flag clear coinciding with a wrap, where a wrong priority drops the overflow. It also tests a count written above the compare value in clear-on-compare mode, which must run on to 255, wrap, and flag overflow. Tick taps that are not selected are pulsed to expose a wrong select decode.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    typedef enum logic [1:0] {
        WM_WRAP     = 2'd0,
        WM_DUAL     = 2'd1,
        WM_CMPCLR   = 2'd2,
        WM_WRAP_ALT = 2'd3
    } wave_mode_e;

    localparam logic [2:0] SEL_STOP = 3'd0;
    localparam logic [2:0] SEL_SYS  = 3'd1;
    localparam logic [2:0] SEL_TAP0 = 3'd2;

endpackage

// File: rtl/tcu_tick_sel.sv
module tcu_tick_sel #(
    parameter int NTAP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      clk_sel,
    input  logic [NTAP-1:0] presc_tick,
    input  logic            ext_tick,
    output logic            tick
);
    import tcu_pkg::*;

    localparam int EXT_FIRST = NTAP + 2;

    always_comb begin
        tick = 1'b0;
        if (clk_sel == SEL_SYS) begin
            tick = 1'b1;
        end else if (int'(clk_sel) >= EXT_FIRST) begin
            tick = ext_tick;
        end else begin
            for (int i = 0; i < NTAP; i++) begin
                if (int'(clk_sel) == i + 2) tick = presc_tick[i];
            end
        end
    end

    // R3: a stopped source never produces a tick
    p_stop_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == SEL_STOP) |-> !tick);

    // R4: external codes follow ext_tick only
    p_ext_gate_r4: assert property (@(posedge clk) disable iff (rst)
        ((int'(clk_sel) >= EXT_FIRST) && !ext_tick) |-> !tick);

endmodule

// File: rtl/tcu_next_count.sv
module tcu_next_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   wave_mode,
    input  logic [W-1:0] cnt,
    input  logic         dir_down,
    input  logic [W-1:0] cmp_val,
    input  logic         tick,
    output logic [W-1:0] cnt_nxt,
    output logic         dir_nxt,
    output logic         wrap_evt,
    output logic [W-1:0] top_val
);
    import tcu_pkg::*;

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    wave_mode_e mode;
    assign mode    = wave_mode_e'(wave_mode);
    assign top_val = (mode == WM_CMPCLR) ? cmp_val : MAXV;

    always_comb begin
        cnt_nxt  = cnt + ONE;
        dir_nxt  = 1'b0;
        wrap_evt = (cnt == MAXV);
        unique case (mode)
            WM_DUAL: begin
                if (!dir_down) begin
                    wrap_evt = 1'b0;
                    if (cnt == MAXV) begin
                        dir_nxt = 1'b1;
                        cnt_nxt = MAXV - ONE;
                    end
                end else begin
                    dir_nxt  = 1'b1;
                    cnt_nxt  = cnt - ONE;
                    wrap_evt = (cnt == ONE);
                    if (cnt == '0) begin
                        dir_nxt = 1'b0;
                        cnt_nxt = ONE;
                    end
                end
            end
            WM_CMPCLR: begin
                if (cnt == cmp_val) cnt_nxt = '0;
            end
            default: ;
        endcase
    end

    // R9: a dual-slope tick never produces an end value twice in a row
    p_dual_no_repeat_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == WM_DUAL) |-> (cnt_nxt != cnt));

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
    parameter int W    = 8,
    parameter int NTAP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      clk_sel,
    input  logic [NTAP-1:0] presc_tick,
    input  logic            ext_tick,
    input  logic [1:0]      wave_mode,
    input  logic [W-1:0]    cmp_val,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    input  logic            flag_clr,
    output logic [W-1:0]    count_o,
    output logic            at_top,
    output logic            at_bottom,
    output logic            ovf_flag
);
    import tcu_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir_down;
        logic         ovf;
    } tcu_state_t;

    tcu_state_t st_d, st_q;

    logic         tick;
    logic [W-1:0] cnt_nxt;
    logic         dir_nxt;
    logic         wrap_evt;
    logic [W-1:0] top_val;

    tcu_tick_sel #(.NTAP(NTAP)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .clk_sel    (clk_sel),
        .presc_tick (presc_tick),
        .ext_tick   (ext_tick),
        .tick       (tick)
    );

    tcu_next_count #(.W(W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wave_mode (wave_mode),
        .cnt       (st_q.cnt),
        .dir_down  (st_q.dir_down),
        .cmp_val   (cmp_val),
        .tick      (tick),
        .cnt_nxt   (cnt_nxt),
        .dir_nxt   (dir_nxt),
        .wrap_evt  (wrap_evt),
        .top_val   (top_val)
    );

    always_comb begin
        st_d = st_q;
        if (wave_mode != WM_DUAL) st_d.dir_down = 1'b0;
        if (flag_clr) st_d.ovf = 1'b0;
        if (wr_en) begin
            st_d.cnt = wr_data;
        end else if (tick) begin
            st_d.cnt      = cnt_nxt;
            st_d.dir_down = dir_nxt;
            if (wrap_evt) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_o   = st_q.cnt;
    assign at_bottom = (st_q.cnt == '0);
    assign at_top    = (st_q.cnt == top_val);
    assign ovf_flag  = st_q.ovf;

    // R1: single-slope tick adds one, modulo the width
    p_step_up_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && wave_mode == WM_WRAP) |=> (count_o == $past(count_o) + ONE));

    // R2: compare match clears on a tick
    p_cmp_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && wave_mode == WM_CMPCLR && count_o == cmp_val) |=> (count_o == '0));

    // R3: stopped timer holds the count
    p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == SEL_STOP && !wr_en) |=> $stable(count_o));

    // R5: a write always lands
    p_wr_load_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count_o == $past(wr_data)));

    // R8: the flag is sticky without a clear
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    // R9: dual slope turns upward at zero
    p_dual_turn_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && wave_mode == WM_DUAL && count_o == '0) |=> (count_o == ONE));

endmodule

// File: tb/sim_tmr_count_unit.sv
`timescale 1ns/1ps
module sim_tmr_count_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] clk_sel;
    logic [3:0] presc_tick;
    logic       ext_tick;
    logic [1:0] wave_mode;
    logic [7:0] cmp_val;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       flag_clr;
    logic [7:0] count_o;
    logic       at_top, at_bottom, ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_count_unit u0 (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .presc_tick(presc_tick),
        .ext_tick(ext_tick), .wave_mode(wave_mode), .cmp_val(cmp_val),
        .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
        .count_o(count_o), .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        clk_sel = 3'd0; wr_en = 1'b1; wr_data = v;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic clr_flag();
        clk_sel = 3'd0; flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        chk("R8 flag cleared", ovf_flag, 0);
    endtask

    task automatic t_reset();
        chk("R10 reset count", count_o, 0);
        chk("R10 reset flag", ovf_flag, 0);
        chk("R6 bottom at zero", at_bottom, 1);
        chk("R6 top low at zero", at_top, 0);
    endtask

    task automatic t_up_and_stop();
        wave_mode = 2'd0; clk_sel = 3'd1;
        cyc(5);
        chk("R1 up count", count_o, 5);
        clk_sel = 3'd0; presc_tick = 4'hF; ext_tick = 1'b1;
        cyc(10);
        presc_tick = 4'h0; ext_tick = 1'b0;
        chk("R3 stopped hold", count_o, 5);
    endtask

    task automatic t_select();
        clk_sel = 3'd6;
        for (int k = 0; k < 3; k++) begin
            ext_tick = 1'b1; cyc(1); ext_tick = 1'b0; cyc(2);
        end
        chk("R4 external ticks", count_o, 8);
        clk_sel = 3'd3;
        presc_tick = 4'b0001; cyc(1); presc_tick = 4'b0000; cyc(1);
        chk("R4 unselected tap ignored", count_o, 8);
        presc_tick = 4'b0010; cyc(1); presc_tick = 4'b0000; cyc(1);
        chk("R4 tap1 on code 3", count_o, 9);
        clk_sel = 3'd7; ext_tick = 1'b1; cyc(1); ext_tick = 1'b0;
        chk("R4 code 7 external", count_o, 10);
        clk_sel = 3'd5; presc_tick = 4'b1000; cyc(1); presc_tick = 4'b0000;
        chk("R4 tap3 on code 5", count_o, 11);
        clk_sel = 3'd0;
    endtask

    task automatic t_write();
        wr(8'd200);
        chk("R5 write while stopped", count_o, 200);
        clk_sel = 3'd1; wr_en = 1'b1; wr_data = 8'd50;
        cyc(1);
        wr_en = 1'b0;
        chk("R5 write beats increment", count_o, 50);
        cyc(1);
        chk("R5 count resumes", count_o, 51);
        wr(8'd255);
        clk_sel = 3'd1; wr_en = 1'b1; wr_data = 8'd7;
        cyc(1);
        wr_en = 1'b0; clk_sel = 3'd0;
        chk("R5 write over wrap value", count_o, 7);
        chk("R5 write sets no flag", ovf_flag, 0);
    endtask

    task automatic t_wrap(input logic [1:0] m);
        wave_mode = m;
        wr(8'd253);
        clk_sel = 3'd1;
        cyc(2);
        chk("R6 top at 255", at_top, 1);
        chk("R7 no flag before wrap", ovf_flag, 0);
        cyc(1);
        chk("R1 wrap to zero", count_o, 0);
        chk("R7 flag on wrap", ovf_flag, 1);
        cyc(1);
        clk_sel = 3'd0;
        chk("R8 flag sticky", ovf_flag, 1);
        clr_flag();
    endtask

    task automatic t_set_clr_race();
        wave_mode = 2'd0;
        wr(8'd255);
        clk_sel = 3'd1; flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0; clk_sel = 3'd0;
        chk("R8 set wins over clear", ovf_flag, 1);
        clr_flag();
    endtask

    task automatic t_cmp();
        wave_mode = 2'd2; cmp_val = 8'd9;
        wr(8'd7);
        clk_sel = 3'd1;
        cyc(1);
        chk("R2 below compare", count_o, 8);
        chk("R6 top low below compare", at_top, 0);
        cyc(1);
        chk("R6 top at compare", at_top, 1);
        cyc(1);
        chk("R2 clear at compare", count_o, 0);
        chk("R7 compare clear no flag", ovf_flag, 0);
        clk_sel = 3'd0;
        wr(8'd9);
        clk_sel = 3'd1; wr_en = 1'b1; wr_data = 8'd100;
        cyc(1);
        wr_en = 1'b0; clk_sel = 3'd0;
        chk("R5 write beats compare clear", count_o, 100);
        wr(8'd254);
        clk_sel = 3'd1;
        cyc(2);
        clk_sel = 3'd0;
        chk("R7 above compare wraps", count_o, 0);
        chk("R7 above compare flag", ovf_flag, 1);
        clr_flag();
    endtask

    task automatic t_dual();
        int seq_up [4] = '{254, 255, 254, 253};
        int seq_dn [4] = '{1, 0, 1, 2};
        wave_mode = 2'd1;
        wr(8'd253);
        clk_sel = 3'd1;
        for (int k = 0; k < 4; k++) begin
            cyc(1);
            chk("R9 dual top turn", count_o, seq_up[k]);
        end
        wr(8'd2);
        clk_sel = 3'd1;
        for (int k = 0; k < 4; k++) begin
            cyc(1);
            chk("R9 dual bottom turn", count_o, seq_dn[k]);
            if (k == 1) chk("R9 flag at zero", ovf_flag, 1);
            if (k == 0) chk("R9 no flag at one", ovf_flag, 0);
        end
        clk_sel = 3'd0;
        clr_flag();
    endtask

    initial begin
        rst = 1'b1; clk_sel = 3'd0; presc_tick = 4'h0; ext_tick = 1'b0;
        wave_mode = 2'd0; cmp_val = 8'd0; wr_en = 1'b0; wr_data = 8'd0; flag_clr = 1'b0;
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_up_and_stop();
        t_select();
        t_write();
        t_wrap(2'd0);
        t_wrap(2'd3);
        t_set_clr_race();
        t_cmp();
        t_dual();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule